// File: doc/BRIEF.md
# Dual Clock Output Divider and Source Selector

This block sits after a frequency synthesiser and forms two output clocks from a reference clock and a VCO clock. A post divider with an even ratio of 2×P, where P is a 5-bit field, serves both the VCO path and the reference path. Output 0 takes one of three sources. Output 1 takes one of four sources, and two of those are built from output 0. Two complete configuration profiles are held at the inputs. A frequency-select pin picks one of them, and the change only takes effect at a rising edge of the reference-divided clock, so switching while running gives no short pulse.

Output enable and power-down both put the outputs into a disabled state. A profile bit sets that state: either high impedance (the drive indication is low) or driven low. Power-down stops every divider. When power-down is released, the dividers restart from zero, and the outputs stay disabled through a fixed start-up window of reference cycles. The synchronous reset acts the same way as power-down.

Top module: `clkgen_out_sel`

## Requirements
- R1: A profile is 10 bits wide: bits [4:0] hold P, [6:5] the output 0 source, [8:7] the output 1 source, and bit 9 the float-when-off bit. A divided path has a period of exactly 2×P cycles of its source clock.
- R2: P = 0 behaves like P = 1, so a divided path has a period of 2 source cycles.
- R3: Every 2×P path has a 50% duty cycle: the high phase lasts P source cycles.
- R4: Output 0 source codes: 0 selects VCO/(2×P), 1 selects the raw reference, 2 selects reference/(2×P), and 3 behaves like 0.
- R5: Output 1 source codes: 0 selects the reference, 1 selects reference/2, 2 selects output 0, and 3 selects output 0 divided by 2.
- R6: While oe_i is 0, both clock outputs are held at 0. Their drive indications are 0 when the active profile's float bit is 1, and 1 when it is 0.
- R7: While pwrdn_n_i or rst_n is 0, all dividers are held at zero and both outputs are in the disabled state described in R6.
- R8: After rst_n and pwrdn_n_i are both high, the outputs stay disabled up to the 15th reference rising edge and are enabled from the 16th.
- R9: fsel_i = 1 selects profile A and fsel_i = 0 selects profile B. A change to fsel_i takes effect at the next rising edge of the reference-divided clock, so the period in progress finishes at the old setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk_i | input | 1 | Reference clock |
| vco_clk_i | input | 1 | VCO clock from the synthesiser |
| rst_n | input | 1 | Synchronous active-low reset, reference domain |
| pwrdn_n_i | input | 1 | Active-low power-down |
| oe_i | input | 1 | Output enable, active high |
| fsel_i | input | 1 | Profile select: 1 = profile A, 0 = profile B |
| prof_a_i | input | 10 | Profile A configuration |
| prof_b_i | input | 10 | Profile B configuration |
| clk0_o | output | 1 | Output clock 0 |
| clk0_drv_o | output | 1 | Output 0 is driven (0 = high impedance) |
| clk1_o | output | 1 | Output clock 1 |
| clk1_drv_o | output | 1 | Output 1 is driven (0 = high impedance) |

## Verification
The bench measures the periods and high times at P = 0, at P = 31, and for the spare output 0 code. If a divider stalls at P = 0, the edge wait never ends. If a divider divides by P instead of 2×P, or counts one cycle too many, the measured period is wrong. It switches the profile in the middle of a high phase and checks that the interval spanning the switch keeps the old period. A design that switches at once would give a short interval there. Probing the drive indication at the 15th and 16th reference edges after power-down release catches a start-up window that is off by one. Disabling with the float bit in both settings catches a design that drives the pin when it should float.

// File: rtl/clkgen_pkg.sv
`timescale 1ns/1ps
// Shared widths, source codes and profile layout for the clock output selector.
package clkgen_pkg;
    parameter int P_W = 5;                    // post divider field width
    localparam int PROF_W = P_W + 5;          // float + src1 + src0 + P

    typedef enum logic [1:0] {
        S0_VCO_DIV = 2'd0,
        S0_REF     = 2'd1,
        S0_REF_DIV = 2'd2,
        S0_SPARE   = 2'd3
    } src0_e;

    typedef enum logic [1:0] {
        S1_REF      = 2'd0,
        S1_REF_HALF = 2'd1,
        S1_OUT0     = 2'd2,
        S1_OUT0_HALF= 2'd3
    } src1_e;

    typedef struct packed {
        logic             float_off;
        src1_e            src1;
        src0_e            src0;
        logic [P_W-1:0]   p;
    } profile_t;
endpackage

// File: rtl/clkgen_even_div.sv
`timescale 1ns/1ps
// Even divider: divides its clock by 2*P with a 50% duty cycle by toggling the
// output every P input cycles. P = 0 is treated as 1. Assumes run_i is
// synchronous to clk_i; while run_i is low the counter and the output are zero.
// rise_o flags the cycle whose closing edge raises div_o.
module clkgen_even_div #(
    parameter int P_W = 5
) (
    input  logic           clk_i,
    input  logic           run_i,
    input  logic [P_W-1:0] p_i,
    output logic           div_o,
    output logic           rise_o
);
    logic [P_W-1:0] cnt_q;
    logic [P_W-1:0] last;
    logic           at_last;

    // Terminal count is P-1, where P = 0 counts as 1.
    always_comb begin
        last    = (p_i == '0) ? '0 : p_i - 1'b1;
        at_last = (cnt_q >= last);
        rise_o  = run_i && !div_o && at_last;
    end

    // Count to the terminal value, then wrap and toggle the output.
    always_ff @(posedge clk_i) begin
        if (!run_i) begin
            cnt_q <= '0;
            div_o <= 1'b0;
        end else if (at_last) begin
            cnt_q <= '0;
            div_o <= ~div_o;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/clkgen_sync.sv
`timescale 1ns/1ps
// Two-stage synchronizer for a vector of slowly changing level signals.
// Assumes each bit is stable for several destination cycles.
module clkgen_sync #(
    parameter int W = 2
) (
    input  logic         clk_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;

    // Two flops in series into the destination domain.
    always_ff @(posedge clk_i) begin
        meta_q <= d_i;
        q_o    <= meta_q;
    end
endmodule

// File: rtl/clkgen_startup.sv
`timescale 1ns/1ps
// Run and ready control in the reference domain. run_o follows reset and
// power-down with one register stage. ready_o rises at the LIM-th reference
// edge after both rst_n and pwrdn_n_i are high, and drops whenever either is low.
module clkgen_startup #(
    parameter int LIM = 16
) (
    input  logic clk_i,
    input  logic rst_n,
    input  logic pwrdn_n_i,
    output logic run_o,
    output logic ready_o
);
    localparam int CW = $clog2(LIM + 1);
    logic [CW-1:0] cnt_q;

    // Register the combined run condition for the dividers.
    always_ff @(posedge clk_i) begin
        run_o <= rst_n && pwrdn_n_i;
    end

    // Count the start-up window, then raise ready.
    always_ff @(posedge clk_i) begin
        if (!rst_n || !pwrdn_n_i) begin
            cnt_q   <= '0;
            ready_o <= 1'b0;
        end else if (!ready_o) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CW'(LIM - 1)) ready_o <= 1'b1;
        end
    end
endmodule

// File: rtl/clkgen_out_sel.sv
`timescale 1ns/1ps
// Dual clock output divider and source selector.
// Builds output 0 from VCO/(2P), the reference, or reference/(2P), and output 1
// from the reference, reference/2, output 0, or output 0/2. Two profiles are
// held at the inputs and fsel_i picks one. The switch is applied in the
// reference domain at a rising edge of the reference divider, and in the VCO
// domain at that divider's own rising edge. Assumes profile inputs are static
// apart from deliberate reprogramming. Clock muxing here is combinational.
module clkgen_out_sel
    import clkgen_pkg::*;
#(
    parameter int STARTUP_CYC = 16
) (
    input  logic              ref_clk_i,
    input  logic              vco_clk_i,
    input  logic              rst_n,
    input  logic              pwrdn_n_i,
    input  logic              oe_i,
    input  logic              fsel_i,
    input  logic [PROF_W-1:0] prof_a_i,
    input  logic [PROF_W-1:0] prof_b_i,
    output logic              clk0_o,
    output logic              clk0_drv_o,
    output logic              clk1_o,
    output logic              clk1_drv_o
);
    profile_t       pa, pb, pr;
    logic           run_r, ready;
    logic           sel_q;
    logic           ref_div, ref_rise, ref_half;
    logic           run_v, sel_v;
    logic [P_W-1:0] p_v_q;
    logic           vco_div, vco_rise;
    logic           clk0_int, clk1_int, h0_q;
    logic           en;

    assign pa = profile_t'(prof_a_i);
    assign pb = profile_t'(prof_b_i);
    assign pr = sel_q ? pa : pb;

    clkgen_startup #(.LIM(STARTUP_CYC)) startup_i (
        .clk_i     (ref_clk_i),
        .rst_n     (rst_n),
        .pwrdn_n_i (pwrdn_n_i),
        .run_o     (run_r),
        .ready_o   (ready)
    );

    // Active profile: follows fsel while stopped, else only at a divided rising edge.
    always_ff @(posedge ref_clk_i) begin
        if (!rst_n || !pwrdn_n_i) sel_q <= fsel_i;
        else if (ref_rise)        sel_q <= fsel_i;
    end

    clkgen_even_div #(.P_W(P_W)) ref_div_i (
        .clk_i  (ref_clk_i),
        .run_i  (run_r),
        .p_i    (pr.p),
        .div_o  (ref_div),
        .rise_o (ref_rise)
    );

    // Reference divided by two.
    always_ff @(posedge ref_clk_i) begin
        if (!run_r) ref_half <= 1'b0;
        else        ref_half <= ~ref_half;
    end

    clkgen_sync #(.W(2)) sync_i (
        .clk_i (vco_clk_i),
        .d_i   ({run_r, sel_q}),
        .q_o   ({run_v, sel_v})
    );

    // VCO-domain P: loaded while stopped or at the VCO divider's rising edge.
    always_ff @(posedge vco_clk_i) begin
        if (!run_v || vco_rise) p_v_q <= sel_v ? pa.p : pb.p;
    end

    clkgen_even_div #(.P_W(P_W)) vco_div_i (
        .clk_i  (vco_clk_i),
        .run_i  (run_v),
        .p_i    (p_v_q),
        .div_o  (vco_div),
        .rise_o (vco_rise)
    );

    // Output 0 source multiplexer.
    always_comb begin
        unique case (pr.src0)
            S0_REF:     clk0_int = ref_clk_i;
            S0_REF_DIV: clk0_int = ref_div;
            default:    clk0_int = vco_div;
        endcase
    end

    // Output 0 divided by two, cleared until the outputs are ready.
    always_ff @(posedge clk0_int) begin
        if (!ready) h0_q <= 1'b0;
        else        h0_q <= ~h0_q;
    end

    // Output 1 source multiplexer.
    always_comb begin
        unique case (pr.src1)
            S1_REF:      clk1_int = ref_clk_i;
            S1_REF_HALF: clk1_int = ref_half;
            S1_OUT0:     clk1_int = clk0_int;
            default:     clk1_int = h0_q;
        endcase
    end

    // Output gating and disabled-state selection.
    always_comb begin
        en         = ready && oe_i;
        clk0_o     = en && clk0_int;
        clk1_o     = en && clk1_int;
        clk0_drv_o = en || !pr.float_off;
        clk1_drv_o = en || !pr.float_off;
    end
endmodule

// File: rtl/clkgen_out_sel_chk.sv
`timescale 1ns/1ps
// Port-level checker for clkgen_out_sel, bound to every instance.
// Samples on the reference clock; holds once rst_n is high.
module clkgen_out_sel_chk #(
    parameter int STARTUP_CYC = 16
) (
    input logic ref_clk_i,
    input logic rst_n,
    input logic pwrdn_n_i,
    input logic oe_i,
    input logic float_a,
    input logic float_b,
    input logic clk0_o,
    input logic clk0_drv_o,
    input logic clk1_o,
    input logic clk1_drv_o
);
    localparam int SW = $clog2(STARTUP_CYC + 1);
    logic [SW-1:0] since_q;

    // Reference cycles since reset and power-down were both released, saturating.
    always_ff @(posedge ref_clk_i) begin
        if (!rst_n || !pwrdn_n_i)          since_q <= '0;
        else if (since_q != SW'(STARTUP_CYC)) since_q <= since_q + 1'b1;
    end

    p_oe_low_r6: assert property (@(posedge ref_clk_i) disable iff (!rst_n)
        !oe_i |-> (!clk0_o && !clk1_o));

    p_oe_float_r6: assert property (@(posedge ref_clk_i) disable iff (!rst_n)
        (!oe_i && float_a && float_b) |-> (!clk0_drv_o && !clk1_drv_o));

    p_oe_drive_r6: assert property (@(posedge ref_clk_i) disable iff (!rst_n)
        (!float_a && !float_b) |-> (clk0_drv_o && clk1_drv_o));

    p_pd_quiet_r7: assert property (@(posedge ref_clk_i) disable iff (!rst_n)
        !pwrdn_n_i |=> (!clk0_o && !clk1_o));

    p_startup_r8: assert property (@(posedge ref_clk_i) disable iff (!rst_n)
        (since_q < SW'(STARTUP_CYC)) |-> (!clk0_o && !clk1_o));
endmodule

bind clkgen_out_sel clkgen_out_sel_chk #(.STARTUP_CYC(STARTUP_CYC)) chk_i (
    .ref_clk_i  (ref_clk_i),
    .rst_n      (rst_n),
    .pwrdn_n_i  (pwrdn_n_i),
    .oe_i       (oe_i),
    .float_a    (prof_a_i[clkgen_pkg::PROF_W-1]),
    .float_b    (prof_b_i[clkgen_pkg::PROF_W-1]),
    .clk0_o     (clk0_o),
    .clk0_drv_o (clk0_drv_o),
    .clk1_o     (clk1_o),
    .clk1_drv_o (clk1_drv_o)
);

// File: tb/clkgen_out_sel_tb.sv
`timescale 1ns/1ps
module clkgen_out_sel_tb_top;
    localparam realtime REF_PERIOD = 10.0;
    localparam realtime VCO_PERIOD = 4.0;

    typedef struct packed {
        logic [9:0] prof;   // {float, src1, src0, P}
        int         per0;   // expected output 0 period, ns
        int         per1;   // expected output 1 period, ns
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{ {1'b0, 2'd2, 2'd0, 5'd3 },  24,  24 },   // R1 R4 R5: VCO/6, out1 = out0
        '{ {1'b0, 2'd3, 2'd2, 5'd5 }, 100, 200 },   // R1 R5: ref/10, out0/2
        '{ {1'b0, 2'd1, 2'd2, 5'd0 },  20,  20 },   // R2: P=0 acts as 1, ref/2
        '{ {1'b0, 2'd0, 2'd1, 5'd7 },  10,  10 },   // R4 R5: raw reference both
        '{ {1'b0, 2'd3, 2'd0, 5'd31}, 248, 496 },   // R1 R5: largest P
        '{ {1'b0, 2'd1, 2'd3, 5'd1 },   8,  20 }    // R4: spare code = VCO path
    };

    logic ref_clk = 1'b0, vco_clk = 1'b0;
    logic rst_n = 1'b0, pwrdn_n = 1'b1, oe = 1'b1, fsel = 1'b1;
    logic [9:0] prof_a = {1'b1, 2'd0, 2'd2, 5'd2};
    logic [9:0] prof_b = {1'b1, 2'd0, 2'd2, 5'd2};
    logic clk0, clk0_drv, clk1, clk1_drv;
    int checks = 0, errors = 0;

    always #(REF_PERIOD / 2) ref_clk = ~ref_clk;
    always #(VCO_PERIOD / 2) vco_clk = ~vco_clk;

    clkgen_out_sel dut_i (
        .ref_clk_i  (ref_clk),
        .vco_clk_i  (vco_clk),
        .rst_n      (rst_n),
        .pwrdn_n_i  (pwrdn_n),
        .oe_i       (oe),
        .fsel_i     (fsel),
        .prof_a_i   (prof_a),
        .prof_b_i   (prof_b),
        .clk0_o     (clk0),
        .clk0_drv_o (clk0_drv),
        .clk1_o     (clk1),
        .clk1_drv_o (clk1_drv)
    );

    task automatic chk(input string req, input real act, input real exp);
        checks++;
        if ((act > exp + 0.01) || (act < exp - 0.01)) begin
            errors++;
            $display("FAIL %s: actual=%0.2f expected=%0.2f", req, act, exp);
        end
    endtask

    // Power-cycle with a new profile A and wait past the start-up window.
    task automatic restart(input logic [9:0] pa);
        @(negedge ref_clk);
        pwrdn_n = 1'b0;
        prof_a  = pa;
        repeat (3) @(negedge ref_clk);
        pwrdn_n = 1'b1;
        repeat (20) @(negedge ref_clk);
    endtask

    // Period and high time of one output, skipping one edge first.
    task automatic meas(input bit which, output real per, output real hi);
        realtime t0, t1, t2;
        if (!which) begin
            @(posedge clk0); @(posedge clk0); t0 = $realtime;
            @(negedge clk0); t1 = $realtime;
            @(posedge clk0); t2 = $realtime;
        end else begin
            @(posedge clk1); @(posedge clk1); t0 = $realtime;
            @(negedge clk1); t1 = $realtime;
            @(posedge clk1); t2 = $realtime;
        end
        per = t2 - t0;
        hi  = t1 - t0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(REF_PERIOD * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        real per, hi, tr, ta, tb;

        // R7: reset state with the float bit set, then cleared.
        repeat (4) @(negedge ref_clk);
        chk("R7 reset clk0", clk0, 0);
        chk("R7 reset drv float", clk0_drv | clk1_drv, 0);
        prof_a = {1'b0, 2'd0, 2'd2, 5'd2};
        #1;
        chk("R7 reset drv low", clk0_drv & clk1_drv, 1);
        chk("R7 reset clk1", clk1, 0);
        @(negedge ref_clk);
        rst_n = 1'b1;

        // R1 R2 R3 R4 R5: walk the table.
        foreach (VECS[i]) begin
            restart(VECS[i].prof);
            meas(1'b0, per, hi);
            chk($sformatf("R1/R4 vec%0d period0", i), per, VECS[i].per0);
            chk($sformatf("R3 vec%0d high0", i), hi, VECS[i].per0 / 2.0);
            meas(1'b1, per, hi);
            chk($sformatf("R5 vec%0d period1", i), per, VECS[i].per1);
        end

        // R6: output enable low, drive-low then float.
        restart({1'b0, 2'd0, 2'd1, 5'd1});
        oe = 1'b0;
        for (int k = 0; k < 4; k++) begin
            #(REF_PERIOD / 4 + 0.3);
            chk("R6 oe off clocks low", clk0 | clk1, 0);
        end
        chk("R6 oe off driven", clk0_drv & clk1_drv, 1);
        @(negedge ref_clk);
        prof_a = {1'b1, 2'd0, 2'd1, 5'd1};
        #1;
        chk("R6 oe off float", clk0_drv | clk1_drv, 0);
        @(negedge ref_clk);
        oe = 1'b1;
        #1;
        chk("R6 oe on driven", clk0_drv & clk1_drv, 1);

        // R7: power-down holds outputs in the disabled state.
        @(negedge ref_clk);
        pwrdn_n = 1'b0;
        repeat (2) @(negedge ref_clk);
        for (int k = 0; k < 4; k++) begin
            #(REF_PERIOD / 4 + 0.3);
            chk("R7 pd clocks low", clk0 | clk1, 0);
        end
        chk("R7 pd float", clk0_drv | clk1_drv, 0);

        // R8: enable appears exactly at the 16th reference edge.
        @(negedge ref_clk);
        pwrdn_n = 1'b1;
        repeat (15) @(posedge ref_clk);
        #1;
        chk("R8 disabled after 15", clk0_drv | clk1_drv, 0);
        @(posedge ref_clk);
        #1;
        chk("R8 enabled at 16", clk0_drv & clk1_drv, 1);

        // R9: switch mid high phase; the spanning period keeps the old value.
        prof_b = {1'b0, 2'd0, 2'd2, 5'd2};
        restart({1'b0, 2'd0, 2'd2, 5'd4});
        @(posedge clk0); @(posedge clk0);
        tr = $realtime;
        #15 fsel = 1'b0;
        @(posedge clk0); ta = $realtime;
        @(posedge clk0); tb = $realtime;
        chk("R9 spanning period old", ta - tr, 80);
        chk("R9 new profile period", tb - ta, 40);
        meas(1'b0, per, hi);
        chk("R9 profile B settled", per, 40);

        finish_run();
    end
endmodule